// File: doc/BRIEF.md
# Master Clock Ratio Monitor

This block runs on an audio master clock. It watches a frame clock that is derived from that master clock. It measures how many master-clock cycles fit into one frame and accepts 256, 384 or 512 with no configuration. Once it has accepted a ratio, it issues a clock enable that marks a steady 256-per-frame processing rate, so downstream logic stays on the master clock and needs no divided clock.

While locked, the block measures every frame period. A small phase step of the frame clock is absorbed. A large step, or a frame edge that never arrives, drops the lock at once and stops the processing enable. After a fresh lock, a ready flag stays low for a fixed number of frames so that downstream filters can settle before their output is used.

Top module: `mclk_ratio_monitor`

## Requirements
- R1: While reset is held, and in the cycle after it, sync_lost_o is 1, ratio_code_o is 0, tick_o is 0 and ready_o is 0.
- R2: Two consecutive frame periods of the same accepted length cause a lock at the rising frame edge that ends the second period. The length is measured in master cycles between rising edges of frame_clk_i. The code is 1 for 256, 2 for 384 and 3 for 512. After the lock, sync_lost_o is 0.
- R3: Two consecutive accepted periods of different lengths do not lock. A following period that matches the second one does lock.
- R4: A period length that is none of 256, 384 or 512 never produces a lock; ratio_code_o stays 0.
- R5: While locked, tick_o is high for exactly 256 cycles of every frame whose period equals the locked ratio. The phase restarts at each frame edge. With ratio 256 it is high every cycle. With 512 it is high on the even cycles after the edge (pattern 1,0). With 384 it follows the pattern 1,1,0.
- R6: While sync_lost_o is 1, tick_o is 0.
- R7: While locked, a frame period that differs from the locked ratio by no more than ratio/16 master cycles keeps the lock. This limit is 4 bit-clock periods at 64 bit clocks per frame. The code and ready_o are unchanged.
- R8: While locked, a frame period that differs from the ratio by more than ratio/16 sets sync_lost_o at that frame edge. At the same edge, ratio_code_o and ready_o go to 0.
- R9: While locked, if no frame edge arrives within ratio + ratio/16 cycles, sync_lost_o rises. For ratio 512 it is first seen 545 cycles after the last edge.
- R10: ready_o rises at the 32nd frame edge after the locking edge, and falls together with any loss of lock.
- R11: After a loss, a new lock needs two more consecutive matching periods, both measured after the losing edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| frame_clk_i | input | 1 | Frame (left/right) clock, synchronous to clk_i |
| ratio_code_o | output | 2 | Locked ratio: 0 none, 1 = 256, 2 = 384, 3 = 512 |
| tick_o | output | 1 | Clock enable at 256 pulses per frame |
| sync_lost_o | output | 1 | High while no lock is held |
| ready_o | output | 1 | High once the recovery time after lock has passed |

## Verification
A table of frame periods drives each exact ratio and also near misses one cycle off each ratio and an unrelated length. The near misses show that classification is exact and is not a range. Each locked row also records the first eight enable values, which separates the three division patterns. Directed sequences place period deviations exactly on the tolerance limit and one cycle past it. They also send a mismatched pair of valid periods, a missing edge to time the watchdog to the cycle, and the 31st versus 32nd frame after lock to find the ready edge.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic [1:0] {
    RC_NONE = 2'd0,
    RC_X1   = 2'd1,
    RC_X15  = 2'd2,
    RC_X2   = 2'd3
  } ratio_e;

  // master cycles per frame for a ratio code
  function automatic int unsigned ratio_cycles(ratio_e c, int unsigned base);
    case (c)
      RC_X1:   return base;
      RC_X15:  return (base * 3) / 2;
      RC_X2:   return base * 2;
      default: return 0;
    endcase
  endfunction

  // exact match of a measured period against the accepted ratios
  function automatic ratio_e classify(int unsigned p, int unsigned base);
    if (p == base)                 return RC_X1;
    else if (p == (base * 3) / 2)  return RC_X15;
    else if (p == base * 2)        return RC_X2;
    else                           return RC_NONE;
  endfunction

  // allowed period deviation in master cycles
  function automatic int unsigned tol_cycles(ratio_e c, int unsigned base,
                                             int unsigned bck_per_frame,
                                             int unsigned tol_bck);
    return (ratio_cycles(c, base) * tol_bck) / bck_per_frame;
  endfunction

  // enable pattern per phase step
  function automatic logic tick_due(ratio_e c, logic [1:0] ph);
    case (c)
      RC_X1:   return 1'b1;
      RC_X15:  return ph != 2'd2;
      RC_X2:   return ph == 2'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] ph_next(ratio_e c, logic [1:0] ph);
    case (c)
      RC_X15:  return (ph == 2'd2) ? 2'd0 : ph + 2'd1;
      RC_X2:   return (ph == 2'd0) ? 2'd1 : 2'd0;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/crs_period_meter.sv
module crs_period_meter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             frame_clk_i,
  output logic             edge_o,
  output logic [CNT_W-1:0] count_o,
  output logic             have_ref_o
);

  logic             fclk_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ref_q;

  assign edge_o     = frame_clk_i && !fclk_q;
  assign count_o    = cnt_q;
  assign have_ref_o = ref_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fclk_q <= 1'b0;
      cnt_q  <= '0;
      ref_q  <= 1'b0;
    end else begin
      fclk_q <= frame_clk_i;
      if (edge_o) begin
        cnt_q <= CNT_W'(1);
        ref_q <= 1'b1;
      end else if (cnt_q != '1) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/crs_lock_fsm.sv
module crs_lock_fsm
  import crs_pkg::*;
#(
  parameter int CNT_W          = 10,
  parameter int BASE_RATIO     = 256,
  parameter int BCK_PER_FRAME  = 64,
  parameter int TOL_BCK        = 4,
  parameter int RECOVER_FRAMES = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             have_ref_i,
  output logic             locked_o,
  output ratio_e           ratio_o,
  output logic             ready_o,
  output logic             lose_o,
  output logic             lock_o
);

  localparam int REC_W = $clog2(RECOVER_FRAMES + 1);

  logic             locked_q;
  ratio_e           ratio_q;
  ratio_e           cand_q;
  logic [REC_W-1:0] rec_q;

  ratio_e      meas;
  int unsigned period;
  int unsigned expect_p;
  int unsigned tol;
  int unsigned dev;

  always_comb begin
    period   = 32'(count_i);
    meas     = classify(period, BASE_RATIO);
    expect_p = ratio_cycles(ratio_q, BASE_RATIO);
    tol      = tol_cycles(ratio_q, BASE_RATIO, BCK_PER_FRAME, TOL_BCK);
    dev      = (period > expect_p) ? period - expect_p : expect_p - period;
    lose_o   = locked_q && ((edge_i && dev > tol) ||
                            (!edge_i && period > expect_p + tol));
    lock_o   = !locked_q && edge_i && have_ref_i &&
               meas != RC_NONE && meas == cand_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      locked_q <= 1'b0;
      ratio_q  <= RC_NONE;
      cand_q   <= RC_NONE;
      rec_q    <= '0;
    end else if (lose_o) begin
      locked_q <= 1'b0;
      ratio_q  <= RC_NONE;
      cand_q   <= RC_NONE;
      rec_q    <= '0;
    end else if (lock_o) begin
      locked_q <= 1'b1;
      ratio_q  <= meas;
      cand_q   <= RC_NONE;
      rec_q    <= '0;
    end else if (!locked_q && edge_i) begin
      cand_q <= have_ref_i ? meas : RC_NONE;
    end else if (locked_q && edge_i && rec_q != REC_W'(RECOVER_FRAMES)) begin
      rec_q <= rec_q + REC_W'(1);
    end
  end

  assign locked_o = locked_q;
  assign ratio_o  = ratio_q;
  assign ready_o  = locked_q && (rec_q == REC_W'(RECOVER_FRAMES));

endmodule

// File: rtl/crs_tick_gen.sv
module crs_tick_gen
  import crs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   edge_i,
  input  logic   locked_i,
  input  ratio_e ratio_i,
  output logic   tick_o
);

  logic [1:0] ph_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || edge_i) ph_q <= 2'd0;
    else                 ph_q <= ph_next(ratio_i, ph_q);
  end

  assign tick_o = locked_i && tick_due(ratio_i, ph_q);

endmodule

// File: rtl/mclk_ratio_monitor.sv
module mclk_ratio_monitor
  import crs_pkg::*;
#(
  parameter int BASE_RATIO     = 256,
  parameter int BCK_PER_FRAME  = 64,
  parameter int TOL_BCK        = 4,
  parameter int RECOVER_FRAMES = 32
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       frame_clk_i,
  output logic [1:0] ratio_code_o,
  output logic       tick_o,
  output logic       sync_lost_o,
  output logic       ready_o
);

  localparam int CNT_W = $clog2(4 * BASE_RATIO);

  logic             frame_edge_w;
  logic [CNT_W-1:0] period_w;
  logic             have_ref_w;
  logic             locked_w;
  logic             lose_w;
  logic             lock_w;
  ratio_e           ratio_w;

  crs_period_meter #(.CNT_W(CNT_W)) meter_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .frame_clk_i(frame_clk_i),
    .edge_o     (frame_edge_w),
    .count_o    (period_w),
    .have_ref_o (have_ref_w)
  );

  crs_lock_fsm #(
    .CNT_W         (CNT_W),
    .BASE_RATIO    (BASE_RATIO),
    .BCK_PER_FRAME (BCK_PER_FRAME),
    .TOL_BCK       (TOL_BCK),
    .RECOVER_FRAMES(RECOVER_FRAMES)
  ) fsm_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .edge_i    (frame_edge_w),
    .count_i   (period_w),
    .have_ref_i(have_ref_w),
    .locked_o  (locked_w),
    .ratio_o   (ratio_w),
    .ready_o   (ready_o),
    .lose_o    (lose_w),
    .lock_o    (lock_w)
  );

  crs_tick_gen tick_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .edge_i  (frame_edge_w),
    .locked_i(locked_w),
    .ratio_i (ratio_w),
    .tick_o  (tick_o)
  );

  assign ratio_code_o = ratio_w;
  assign sync_lost_o  = !locked_w;

endmodule

// File: rtl/crs_checker.sv
module crs_checker (
  input logic       clk_i,
  input logic       rst_i,
  input logic       frame_edge_i,
  input logic       lose_i,
  input logic       lock_i,
  input logic       sync_lost_i,
  input logic [1:0] ratio_i,
  input logic       tick_i,
  input logic       ready_i
);

  p_tick_gated_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    sync_lost_i |-> !tick_i);

  p_code_clear_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    sync_lost_i |-> ratio_i == 2'd0);

  p_code_valid_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !sync_lost_i |-> ratio_i != 2'd0);

  p_lock_on_edge_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (sync_lost_i && !frame_edge_i) |=> sync_lost_i);

  p_lock_event_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    lock_i |=> !sync_lost_i);

  p_loss_event_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    lose_i |=> (sync_lost_i && !ready_i));

  p_ratio_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    !sync_lost_i |=> (sync_lost_i || $stable(ratio_i)));

  p_ready_on_edge_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ready_i && !frame_edge_i) |=> !ready_i);

  p_ready_locked_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    ready_i |-> !sync_lost_i);

  p_full_rate_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    ratio_i == 2'd1 |-> tick_i);

  p_half_rate_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (ratio_i == 2'd3 && tick_i && !frame_edge_i) |=> !tick_i);

  p_two_third_rate_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (ratio_i == 2'd2 && !tick_i && !frame_edge_i) |=> (tick_i || sync_lost_i));

endmodule

bind mclk_ratio_monitor crs_checker chk_i (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .frame_edge_i(frame_edge_w),
  .lose_i      (lose_w),
  .lock_i      (lock_w),
  .sync_lost_i (sync_lost_o),
  .ratio_i     (ratio_code_o),
  .tick_i      (tick_o),
  .ready_i     (ready_o)
);

// File: tb/mclk_ratio_monitor_tb_top.sv
`timescale 1ns/1ps
module mclk_ratio_monitor_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fclk = 1'b0;
  logic [1:0] code;
  logic       tick;
  logic       lost;
  logic       rdy;

  always #4 clk = ~clk;

  mclk_ratio_monitor dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .frame_clk_i (fclk),
    .ratio_code_o(code),
    .tick_o      (tick),
    .sync_lost_o (lost),
    .ready_o     (rdy)
  );

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  int   last_ticks;
  int   lost_at;
  logic [7:0] last_hist;

  // rows: frame period, expected code, expected first eight enables
  localparam int NV = 7;
  localparam int VEC_P [NV] = '{256, 384, 512, 300, 255, 513, 383};
  localparam int VEC_C [NV] = '{1,   2,   3,   0,   0,   0,   0};
  localparam int VEC_H [NV] = '{255, 219, 85,  0,   0,   0,   0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // one frame of p master cycles; rising edge seen at the next posedge
  task automatic frame(input int p);
    last_ticks = 0;
    last_hist  = 8'd0;
    lost_at    = -1;
    fclk = 1'b1;
    for (int k = 0; k < p; k++) begin
      if (k == p / 2) fclk = 1'b0;
      @(negedge clk);
      if (tick) begin
        last_ticks++;
        if (k < 8) last_hist[k] = 1'b1;
      end
      if (lost && lost_at < 0) lost_at = k;
    end
  endtask

  task automatic do_reset();
    rst  = 1'b1;
    fclk = 1'b0;
    repeat (3) @(negedge clk);
    check(lost == 1'b1, "R1 sync_lost", lost, 1);
    check(code == 2'd0, "R1 code", code, 0);
    check(tick == 1'b0, "R1 tick", tick, 0);
    check(rdy == 1'b0,  "R1 ready", rdy, 0);
    rst = 1'b0;
    @(negedge clk);
    check(lost == 1'b1 && rdy == 1'b0, "R1 after release", lost, 1);
  endtask

  initial begin
    @(negedge clk);

    // table walk: R2 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      do_reset();
      repeat (3) frame(VEC_P[i]);
      check(code == 2'(VEC_C[i]), "R2 R4 code", code, VEC_C[i]);
      check(lost == (VEC_C[i] == 0), "R2 R4 sync_lost", lost, int'(VEC_C[i] == 0));
      check(last_ticks == ((VEC_C[i] != 0) ? 256 : 0), "R5 R6 ticks", last_ticks,
            (VEC_C[i] != 0) ? 256 : 0);
      check(last_hist == 8'(VEC_H[i]), "R5 pattern", last_hist, VEC_H[i]);
    end

    // R3: mismatched pair does not lock, matching follow-up does
    do_reset();
    frame(256);
    frame(384);
    frame(384);
    check(lost == 1'b1, "R3 no lock on mismatch", lost, 1);
    frame(384);
    check(code == 2'd2, "R3 lock on match", code, 2);

    // R7 tolerance at the limit
    do_reset();
    repeat (3) frame(256);
    frame(272);
    frame(256);
    check(lost == 1'b0 && code == 2'd1, "R7 +16 kept", code, 1);
    frame(240);
    frame(256);
    check(lost == 1'b0 && code == 2'd1, "R7 -16 kept", code, 1);
    // R8 one cycle past the limit
    frame(273);
    frame(256);
    check(lost == 1'b1, "R8 loss", lost, 1);
    check(code == 2'd0, "R8 code cleared", code, 0);
    // R11 relock needs two fresh periods
    frame(256);
    check(lost == 1'b1, "R11 one period only", lost, 1);
    frame(256);
    check(lost == 1'b0 && code == 2'd1, "R11 relock", code, 1);

    // R9 missing edge at 512
    do_reset();
    repeat (3) frame(512);
    check(code == 2'd3, "R9 setup lock", code, 3);
    frame(1200);
    check(lost_at == 545, "R9 timeout cycle", lost_at, 545);

    // R10 recovery time
    do_reset();
    for (int n = 1; n <= 35; n++) begin
      frame(256);
      if (n == 3)  check(rdy == 1'b0, "R10 not ready at lock", rdy, 0);
      if (n == 34) check(rdy == 1'b0, "R10 31 frames", rdy, 0);
      if (n == 35) check(rdy == 1'b1, "R10 32 frames", rdy, 1);
    end
    frame(270);
    frame(256);
    check(rdy == 1'b1 && lost == 1'b0, "R7 ready kept", rdy, 1);
    frame(200);
    frame(256);
    check(rdy == 1'b0, "R10 R8 ready dropped", rdy, 0);
    check(lost == 1'b1, "R8 loss short", lost, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule